// File: doc/BRIEF.md
# Integer ALU with Branch Compare Support

This block is the purely combinational arithmetic and logic unit of a 32-bit integer datapath. It takes two operands, a 3-bit operation code laid out like the standard integer function field, and three modifier inputs. One modifier chooses the alternate form of an operation. One inverts the second operand. One adds a carry of one into the adder. It returns a full-width result and a flag that is set when that result is zero.

There is no subtract opcode. A subtraction is an add with the second operand inverted and the carry input set. Branch decisions come from the same unit. An equality test subtracts and looks at the zero flag. An ordering test selects one of the set-on-less-than operations, and the branch logic reads the zero flag to find out whether the one-bit answer was 0 or 1.

Top module: `int_alu`

## Requirements
- R1: With op = 000 the result is opa + opb' + carry_in modulo 2^WIDTH, where opb' is the second operand after the optional inversion.
- R2: With op = 000, inv_b = 1 and carry_in = 1, the result is opa - opb (two's complement).
- R3: When inv_b = 1, every operation uses the bitwise complement of opb in place of opb. This includes the shift amount and the compare.
- R4: With op = 001 the result is opa shifted left by opb'[4:0], and zeros fill from the bottom. The other bits of opb' have no effect.
- R5: With op = 101 the result is opa shifted right by opb'[4:0]. The fill is zero when alt = 0 and a copy of opa[31] when alt = 1.
- R6: With op = 010 the result is 1 when opa < opb' in two's complement order and 0 otherwise, and bits 31..1 are always zero. For example, 0x80000000 is less than 0.
- R7: With op = 011 the result is 1 when opa < opb' as unsigned numbers and 0 otherwise, and bits 31..1 are zero.
- R8: op = 100 gives opa XOR opb', op = 110 gives opa OR opb', and op = 111 gives opa AND opb'.
- R9: alt has no effect on any op other than 101. carry_in has no effect on any op other than 000.
- R10: zero is 1 exactly when all result bits are 0.
- R11: For branches, a subtraction with zero = 1 means the operands are equal. Op 010 or 011 with zero = 1 means "greater or equal", and zero = 0 means "less than".

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand (before optional inversion) |
| op | input | 3 | Operation code (000 add, 001 sll, 010 slt, 011 sltu, 100 xor, 101 shift right, 110 or, 111 and) |
| alt | input | 1 | Alternate select: arithmetic right shift for op 101 |
| inv_b | input | 1 | Invert second operand before the operation |
| carry_in | input | 1 | Extra carry of one into the adder |
| result | output | 32 | Operation result |
| zero | output | 1 | Set when result is all zeros |

## Verification
The bench targets the operand pair 0x80000000 and 0 under both compares. A design that drops the sign bias gives the same answer for both, and one that biases both compares misorders unsigned values. Shift amounts with high bits set, and an amount of exactly 32, expose a shifter that reads more than five bits: the result changes instead of wrapping to the low five. A negative value shifted right with alt set, and a positive one with alt set, separate arithmetic fill from logical fill. alt and carry_in are set on every other operation, where a leaky decode would change a logic or compare result. An add that wraps to zero and a self-subtract check that the zero flag is produced from the final result and not from the carry.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

   typedef enum logic [2:0] {
      OP_ADD  = 3'b000,
      OP_SLL  = 3'b001,
      OP_SLT  = 3'b010,
      OP_SLTU = 3'b011,
      OP_XOR  = 3'b100,
      OP_SHR  = 3'b101,
      OP_OR   = 3'b110,
      OP_AND  = 3'b111
   } alu_op_e;

   localparam int ADDER_BEHAVIOURAL = 0;
   localparam int ADDER_RIPPLE      = 1;

   function automatic bit is_pow2(input int v);
      return (v > 1) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/int_alu_adder.sv
module int_alu_adder #(
   parameter int WIDTH = 32,
   parameter int STYLE = 0
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   output logic [WIDTH-1:0] sum
);
   import int_alu_pkg::*;

   generate
      if (STYLE == ADDER_RIPPLE) begin : g_ripple
         logic [WIDTH:0] carry;
         assign carry[0] = cin;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum[i]     = a[i] ^ b[i] ^ carry[i];
            assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
         end
      end else if (STYLE == ADDER_BEHAVIOURAL) begin : g_behav
         assign sum = a + b + {{(WIDTH-1){1'b0}}, cin};
      end else begin : g_bad_style
         $error("int_alu_adder: unsupported STYLE");
      end
   endgenerate

endmodule

// File: rtl/int_alu_shifter.sv
module int_alu_shifter #(
   parameter int WIDTH = 32,
   localparam int AMT_W = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] data,
   input  logic [AMT_W-1:0] amount,
   input  logic             to_left,
   input  logic             arith,
   output logic [WIDTH-1:0] shifted
);

   logic [WIDTH-1:0] pre;
   logic [WIDTH-1:0] stage [AMT_W+1];
   logic             fill;

   // a left shift is a right shift of the bit-reversed word
   always_comb begin
      for (int i = 0; i < WIDTH; i++) begin
         pre[i] = to_left ? data[WIDTH-1-i] : data[i];
      end
   end

   assign fill     = arith & ~to_left & data[WIDTH-1];
   assign stage[0] = pre;

   generate
      for (genvar s = 0; s < AMT_W; s++) begin : g_stage
         localparam int STEP = 1 << s;
         assign stage[s+1] = amount[s]
            ? {{STEP{fill}}, stage[s][WIDTH-1:STEP]}
            : stage[s];
      end
   endgenerate

   always_comb begin
      for (int i = 0; i < WIDTH; i++) begin
         shifted[i] = to_left ? stage[AMT_W][WIDTH-1-i] : stage[AMT_W][i];
      end
   end

endmodule

// File: rtl/int_alu_compare.sv
module int_alu_compare #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             signed_mode,
   output logic             less
);

   logic [WIDTH-1:0] a_bias;
   logic [WIDTH-1:0] b_bias;
   logic [WIDTH:0]   diff;

   // flipping the sign bit maps two's complement order onto unsigned order
   assign a_bias = {a[WIDTH-1] ^ signed_mode, a[WIDTH-2:0]};
   assign b_bias = {b[WIDTH-1] ^ signed_mode, b[WIDTH-2:0]};
   assign diff   = {1'b0, a_bias} - {1'b0, b_bias};
   assign less   = diff[WIDTH];

endmodule

// File: rtl/int_alu.sv
module int_alu #(
   parameter int WIDTH       = 32,
   parameter int ADDER_STYLE = 0,
   localparam int AMT_W      = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic [2:0]       op,
   input  logic             alt,
   input  logic             inv_b,
   input  logic             carry_in,
   output logic [WIDTH-1:0] result,
   output logic             zero
);
   import int_alu_pkg::*;

   generate
      if (!is_pow2(WIDTH)) begin : g_bad_width
         $error("int_alu: WIDTH must be a power of two");
      end
   endgenerate

   alu_op_e          op_e;
   logic [WIDTH-1:0] b_eff;
   logic [WIDTH-1:0] add_out;
   logic [WIDTH-1:0] shift_out;
   logic             lt_out;
   logic             cmp_signed;
   logic             shift_left;
   logic             add_cin;

   assign op_e       = alu_op_e'(op);
   assign b_eff      = inv_b ? ~opb : opb;
   assign add_cin    = carry_in & (op_e == OP_ADD);
   assign cmp_signed = (op_e == OP_SLT);
   assign shift_left = (op_e == OP_SLL);

   int_alu_adder #(.WIDTH(WIDTH), .STYLE(ADDER_STYLE)) u_adder (
      .a   (opa),
      .b   (b_eff),
      .cin (add_cin),
      .sum (add_out)
   );

   int_alu_shifter #(.WIDTH(WIDTH)) u_shifter (
      .data    (opa),
      .amount  (b_eff[AMT_W-1:0]),
      .to_left (shift_left),
      .arith   (alt),
      .shifted (shift_out)
   );

   int_alu_compare #(.WIDTH(WIDTH)) u_compare (
      .a           (opa),
      .b           (b_eff),
      .signed_mode (cmp_signed),
      .less        (lt_out)
   );

   always_comb begin
      unique case (op_e)
         OP_ADD:          result = add_out;
         OP_SLL, OP_SHR:  result = shift_out;
         OP_SLT, OP_SLTU: result = {{(WIDTH-1){1'b0}}, lt_out};
         OP_XOR:          result = opa ^ b_eff;
         OP_OR:           result = opa | b_eff;
         OP_AND:          result = opa & b_eff;
         default:         result = '0;
      endcase
   end

   assign zero = ~|result;

endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
   parameter int WIDTH = 32,
   localparam int AMT_W = $clog2(WIDTH)
) (
   input logic [WIDTH-1:0] opa,
   input logic [WIDTH-1:0] opb,
   input logic [2:0]       op,
   input logic             alt,
   input logic             inv_b,
   input logic             carry_in,
   input logic [WIDTH-1:0] result,
   input logic             zero
);

   logic [WIDTH-1:0] b_seen;
   logic             known;

   assign b_seen = inv_b ? ~opb : opb;
   assign known  = !$isunknown({opa, opb, op, alt, inv_b, carry_in, result, zero});

   always_comb begin
      if (known) begin
         // R10
         a_r10_zero_clear: assert (!zero || result == '0);
         // R6 R7
         a_r6_compare_narrow: assert (!(op == 3'b010 || op == 3'b011) || result[WIDTH-1:1] == '0);
         // R8
         a_r8_or_covers: assert (op != 3'b110 || (result & opa) == opa);
         a_r8_and_within: assert (op != 3'b111 || (result & ~opa) == '0);
         // R4
         a_r4_shift_none: assert (!(op == 3'b001 && b_seen[AMT_W-1:0] == '0) || result == opa);
         // R5
         a_r5_arith_sign: assert (!(op == 3'b101 && alt) || result[WIDTH-1] == opa[WIDTH-1]);
         a_r5_logical_fill: assert (!(op == 3'b101 && !alt && b_seen[AMT_W-1:0] != '0)
                                    || !result[WIDTH-1]);
         // R2
         a_r2_self_sub: assert (!(op == 3'b000 && inv_b && carry_in && opa == opb) || zero);
      end
   end

endmodule

bind int_alu int_alu_chk #(.WIDTH(WIDTH)) u_chk (
   .opa      (opa),
   .opb      (opb),
   .op       (op),
   .alt      (alt),
   .inv_b    (inv_b),
   .carry_in (carry_in),
   .result   (result),
   .zero     (zero)
);

// File: tb/int_alu_tb.sv
module int_alu_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] opa = '0;
   logic [31:0] opb = '0;
   logic [2:0]  op = '0;
   logic        alt = 1'b0;
   logic        inv_b = 1'b0;
   logic        carry_in = 1'b0;
   logic [31:0] result;
   logic        zero;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   int_alu u_dut (
      .opa(opa), .opb(opb), .op(op), .alt(alt), .inv_b(inv_b),
      .carry_in(carry_in), .result(result), .zero(zero)
   );

   function automatic logic [31:0] model(input logic [2:0] o, input logic [31:0] a,
                                         input logic [31:0] b, input logic al,
                                         input logic nv, input logic ci);
      longint unsigned ua, ub, s;
      int sa, sb, sh;
      logic [31:0] bb;
      bb = nv ? ~b : b;
      ua = a; ub = bb; sa = a; sb = bb; sh = bb % 32;
      case (o)
         3'd0: begin s = ua + ub + ci; return s[31:0]; end
         3'd1: return a << sh;
         3'd2: return (sa < sb) ? 32'd1 : 32'd0;
         3'd3: return (ua < ub) ? 32'd1 : 32'd0;
         3'd4: return a ^ bb;
         3'd5: return al ? 32'(sa >>> sh) : (a >> sh);
         3'd6: return a | bb;
         default: return a & bb;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] exp);
      n_cmp++;
      if (result !== exp || zero !== (exp == 0)) begin
         n_bad++;
         $display("FAIL %s: result=%h zero=%b expected result=%h zero=%b",
                  tag, result, zero, exp, exp == 0);
      end
   endtask

   task automatic run(input string tag, input logic [2:0] o, input logic [31:0] a,
                      input logic [31:0] b, input logic al, input logic nv,
                      input logic ci, input logic [31:0] exp);
      @(negedge clk);
      op = o; opa = a; opb = b; alt = al; inv_b = nv; carry_in = ci;
      #2;
      chk(tag, exp);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(100000 * 10);
      n_bad++;
      $display("FAIL watchdog: expired expected completion");
      finish_run();
   end

   initial begin
      string tg;
      logic [31:0] ra, rb;
      logic [2:0]  ro;
      logic        ral, rnv, rci;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk); #2;
      chk("R10 reset idle", 32'h0);

      run("R1 add",            3'd0, 32'd5, 32'd7, 0, 0, 0, 32'd12);
      run("R1 add carry",      3'd0, 32'd5, 32'd7, 0, 0, 1, 32'd13);
      run("R10 add wrap zero", 3'd0, 32'hFFFFFFFF, 32'd1, 0, 0, 0, 32'h0);
      run("R2 sub",            3'd0, 32'd10, 32'd3, 0, 1, 1, 32'd7);
      run("R2 sub negative",   3'd0, 32'd3, 32'd10, 0, 1, 1, 32'hFFFFFFF9);
      run("R11 equal",         3'd0, 32'h1234ABCD, 32'h1234ABCD, 0, 1, 1, 32'h0);
      run("R11 not equal",     3'd0, 32'h1234ABCD, 32'h1234ABCC, 0, 1, 1, 32'h1);
      run("R3 inv xor",        3'd4, 32'h0, 32'h0, 0, 1, 0, 32'hFFFFFFFF);
      run("R3 inv or",         3'd6, 32'h00000100, 32'hFFFF0000, 0, 1, 0, 32'h0000FFFF);
      run("R3 inv shift amt",  3'd1, 32'h1, 32'hFFFFFFFE, 0, 1, 0, 32'h2);
      run("R4 sll 31",         3'd1, 32'h1, 32'd31, 0, 0, 0, 32'h80000000);
      run("R4 sll high bits",  3'd1, 32'h1, 32'hFFFFFFE3, 0, 0, 0, 32'h8);
      run("R4 sll 32 wraps",   3'd1, 32'hA5, 32'd32, 0, 0, 0, 32'hA5);
      run("R5 srl",            3'd5, 32'h80000000, 32'd4, 0, 0, 0, 32'h08000000);
      run("R5 sra negative",   3'd5, 32'h80000000, 32'd4, 1, 0, 0, 32'hF8000000);
      run("R5 sra positive",   3'd5, 32'h40000000, 32'd4, 1, 0, 0, 32'h04000000);
      run("R5 sra 31",         3'd5, 32'h80000000, 32'd31, 1, 0, 0, 32'hFFFFFFFF);
      run("R6 slt min<0",      3'd2, 32'h80000000, 32'h0, 0, 0, 0, 32'h1);
      run("R6 slt 0<min",      3'd2, 32'h0, 32'h80000000, 0, 0, 0, 32'h0);
      run("R6 slt equal",      3'd2, 32'd9, 32'd9, 0, 0, 0, 32'h0);
      run("R7 sltu min<0",     3'd3, 32'h80000000, 32'h0, 0, 0, 0, 32'h0);
      run("R7 sltu 0<min",     3'd3, 32'h0, 32'h80000000, 0, 0, 0, 32'h1);
      run("R11 bge taken",     3'd2, 32'hFFFFFFFF, 32'hFFFFFFFE, 0, 0, 0, 32'h0);
      run("R11 bltu taken",    3'd3, 32'd1, 32'hFFFFFFFF, 0, 0, 0, 32'h1);
      run("R8 xor",            3'd4, 32'hF0F0F0F0, 32'hFF00FF00, 0, 0, 0, 32'h0FF00FF0);
      run("R8 or",             3'd6, 32'hF0F0F0F0, 32'h0F000000, 0, 0, 0, 32'hFFF0F0F0);
      run("R8 and",            3'd7, 32'hF0F0F0F0, 32'hFF00FF00, 0, 0, 0, 32'hF000F000);
      run("R9 alt on add",     3'd0, 32'd5, 32'd7, 1, 0, 0, 32'd12);
      run("R9 alt on sll",     3'd1, 32'h80000001, 32'd1, 1, 0, 0, 32'h2);
      run("R9 alt on slt",     3'd2, 32'h0, 32'h80000000, 1, 0, 0, 32'h0);
      run("R9 alt on sltu",    3'd3, 32'h80000000, 32'h0, 1, 0, 0, 32'h0);
      run("R9 alt on xor",     3'd4, 32'h1, 32'h3, 1, 0, 0, 32'h2);
      run("R9 alt on or",      3'd6, 32'h1, 32'h2, 1, 0, 0, 32'h3);
      run("R9 alt on and",     3'd7, 32'h3, 32'h6, 1, 0, 0, 32'h2);
      run("R9 cin on xor",     3'd4, 32'h5, 32'h5, 0, 0, 1, 32'h0);
      run("R9 cin on sltu",    3'd3, 32'h5, 32'h5, 0, 0, 1, 32'h0);
      run("R9 cin on srl",     3'd5, 32'h10, 32'd4, 0, 0, 1, 32'h1);

      for (int i = 0; i < 3000; i++) begin
         ro = 3'($urandom); ra = $urandom; rb = $urandom;
         ral = 1'($urandom); rnv = 1'($urandom); rci = 1'($urandom);
         if (i % 7 == 0) rb = ra;
         case (ro)
            3'd0: tg = "R1 random add";
            3'd1: tg = "R4 random sll";
            3'd2: tg = "R6 random slt";
            3'd3: tg = "R7 random sltu";
            3'd5: tg = "R5 random shr";
            default: tg = "R8 random logic";
         endcase
         run(tg, ro, ra, rb, ral, rnv, rci, model(ro, ra, rb, ral, rnv, rci));
      end

      finish_run();
   end

endmodule